// File: doc/BRIEF.md
# USB PD packet receive framer

This block sits behind a BMC clock-recovery stage. It receives one recovered line bit per strobe and turns a burst of bits into a USB Power Delivery message. It first requires a run of alternating bits, which is the preamble. It then slides a 20-bit window over the stream and looks for a start-of-packet ordered set. Once that set is found, it splits the stream into 5-bit symbols and maps each one back to a nibble. From the nibbles it rebuilds the 16-bit header and up to seven 32-bit data objects. It then checks the received CRC-32 against its own and checks the end-of-packet symbol.

Each burst produces exactly one outcome, as a single-cycle pulse:
- a good packet,
- a hard-reset event, or
- an error with a code.

After the outcome, further bits are ignored until the upstream stage marks the end of the burst. Higher layers read the header and the objects when the good-packet pulse arrives. A hard reset and the unsupported start-of-packet variants get their own reporting, so a port state machine can react at once.

Bits are taken in arrival order. Inside every 5-bit code, the first bit on the wire is bit 0. In an ordered set, the first symbol sits in the low 5 bits of the window. In this brief, codes are written bit 4 down to bit 0.

Top module: `pdrx_framer`

## Requirements
- R1: While reset is held and in the first cycle after it, `pkt_ok`, `hard_rst` and `err_vld` are low and `err_code` is 0.
- R2: At least PRE_MIN consecutive alternating bits must arrive before any ordered set is searched. If a burst ends while this is still unmet and at least one bit was received, `err_vld` pulses with `err_code` 1.
- R3: A window of Sync-1, Sync-1, Sync-1, Sync-2 starts a packet. Sync-1 is 11000 and Sync-2 is 10001. A packet with good CRC and end-of-packet raises `pkt_ok` for one cycle, and `rx_hdr` then holds the header. The header is sent as four nibbles, least significant first.
- R4: The number of data objects equals header bits 14:12. Object k appears on `rx_obj[32k+31:32k]`, each sent as eight nibbles, least significant first. Objects beyond the count read as zero after a packet.
- R5: Data codes map to nibbles 0..F as follows: 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R6: The CRC-32 covers the header and the objects, bit 0 first. It uses the reflected polynomial EDB88320, an all-ones start and an inverted result, and is sent like a data object. A mismatch gives `err_code` 5 as soon as the CRC field completes.
- R7: Only the first four bits of the end-of-packet code 01101 are compared, so a burst that ends before its fifth bit is still a good packet. Any other four bits give `err_code` 6.
- R8: Three RST-1 (00111) followed by RST-2 (11001) in the window raises `hard_rst` for one cycle and no packet.
- R9: Sync-1, Sync-1, Sync-3, Sync-3 or Sync-1, Sync-3, Sync-1, Sync-3 (Sync-3 = 00110) ends reception with `err_code` 3.
- R10: Either of the following discards the packet with `err_code` 4 and no `pkt_ok`: a burst ending before the CRC field completes, or a non-data code inside the header, objects or CRC.
- R11: A burst ending during the search, or HUNT_MAX searched bits with no ordered set, gives `err_code` 2.
- R12: After any outcome, bits are ignored and raise nothing until `burst_end`. The next burst is then decoded normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_vld | input | 1 | Strobe: `bit_in` carries a new line bit |
| bit_in | input | 1 | Recovered line bit |
| burst_end | input | 1 | Pulse marking end of the received burst; takes priority over a bit in the same cycle |
| pkt_ok | output | 1 | One-cycle pulse: good packet decoded |
| hard_rst | output | 1 | One-cycle pulse: hard-reset ordered set seen |
| err_vld | output | 1 | One-cycle pulse: burst rejected |
| err_code | output | 3 | Error code of the last rejection (1 preamble, 2 no start, 3 unsupported start, 4 length, 5 CRC, 6 end-of-packet) |
| rx_hdr | output | 16 | Received header |
| rx_obj | output | 224 | Seven received data objects, object 0 in the low bits |

## Verification
The hardest state to reach from the ports is a good packet whose end-of-packet code loses its last bit. The same applies to a packet whose CRC field completes just as the burst is cut. Both need a full, correctly encoded frame with a correct CRC, followed by an exact number of trailing bits. The stimulus therefore builds every frame bit by bit: preamble, ordered set, 5-bit coded nibbles and a CRC computed in the bench. Single fields are then altered on purpose: the CRC, the end-of-packet code, the cut point, or an illegal code in the body. A second, complete frame sent inside the ignore window shows that the block stays silent until the burst ends.

// File: rtl/pdrx_pkg.sv
package pdrx_pkg;

  // 5-bit line codes, bit 0 is first on the wire
  localparam logic [4:0] SYM_S1   = 5'b11000;
  localparam logic [4:0] SYM_S2   = 5'b10001;
  localparam logic [4:0] SYM_S3   = 5'b00110;
  localparam logic [4:0] SYM_RST1 = 5'b00111;
  localparam logic [4:0] SYM_RST2 = 5'b11001;
  localparam logic [4:0] SYM_EOP  = 5'b01101;

  // ordered sets, first symbol in the low bits
  localparam logic [19:0] OS_SOP  = {SYM_S2, SYM_S1, SYM_S1, SYM_S1};
  localparam logic [19:0] OS_SOP1 = {SYM_S3, SYM_S3, SYM_S1, SYM_S1};
  localparam logic [19:0] OS_SOP2 = {SYM_S3, SYM_S1, SYM_S3, SYM_S1};
  localparam logic [19:0] OS_HRST = {SYM_RST2, SYM_RST1, SYM_RST1, SYM_RST1};

  localparam int CNT_W   = 3;
  localparam int OBJ_MAX = (1 << CNT_W) - 1;

  localparam logic [31:0] CRC_POLY_R = 32'hEDB88320;

  typedef enum logic [2:0] {
    E_NONE = 3'd0, E_PRE = 3'd1, E_SOP = 3'd2, E_SOPX = 3'd3,
    E_LEN  = 3'd4, E_CRC = 3'd5, E_EOP = 3'd6
  } pdrx_err_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HUNT, ST_BODY, ST_EOP, ST_DRAIN
  } pdrx_st_e;

  typedef enum logic [1:0] {FLD_HDR, FLD_DATA, FLD_CRC} pdrx_fld_e;

  // four serial CRC steps, bit 0 of the nibble first
  function automatic logic [31:0] crc_step_nib(input logic [31:0] c_in,
                                               input logic [3:0]  d);
    logic [31:0] c;
    logic        fb;
    c = c_in;
    for (int i = 0; i < 4; i++) begin
      fb = c[0] ^ d[i];
      c  = c >> 1;
      if (fb) c = c ^ CRC_POLY_R;
    end
    return c;
  endfunction

endpackage

// File: rtl/pdrx_pre.sv
module pdrx_pre #(
  parameter int PRE_MIN = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic bit_vld,
  input  logic bit_in,
  output logic hit,
  output logic seen
);
  localparam int CW = $clog2(PRE_MIN + 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          prev_q, prev_n;

  always_comb begin
    cnt_n  = cnt_q;
    prev_n = prev_q;
    if (!arm) begin
      cnt_n = '0;
    end else if (bit_vld) begin
      prev_n = bit_in;
      if (cnt_q == '0 || bit_in != prev_q)
        cnt_n = (cnt_q == CW'(PRE_MIN)) ? cnt_q : cnt_q + 1'b1;
      else
        cnt_n = CW'(1);
    end
  end

  assign hit  = arm & bit_vld & (cnt_n == CW'(PRE_MIN));
  assign seen = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      prev_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      prev_q <= prev_n;
    end
  end
endmodule

// File: rtl/pdrx_symdec.sv
module pdrx_symdec (
  input  logic [4:0] code,
  output logic [3:0] nib,
  output logic       is_data
);
  always_comb begin
    is_data = 1'b1;
    nib     = 4'h0;
    case (code)
      5'b11110: nib = 4'h0;
      5'b01001: nib = 4'h1;
      5'b10100: nib = 4'h2;
      5'b10101: nib = 4'h3;
      5'b01010: nib = 4'h4;
      5'b01011: nib = 4'h5;
      5'b01110: nib = 4'h6;
      5'b01111: nib = 4'h7;
      5'b10010: nib = 4'h8;
      5'b10011: nib = 4'h9;
      5'b10110: nib = 4'hA;
      5'b10111: nib = 4'hB;
      5'b11010: nib = 4'hC;
      5'b11011: nib = 4'hD;
      5'b11100: nib = 4'hE;
      5'b11101: nib = 4'hF;
      default:  is_data = 1'b0;
    endcase
  end
endmodule

// File: rtl/pdrx_crc32.sv
module pdrx_crc32
  import pdrx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        en,
  input  logic [3:0]  nib,
  output logic [31:0] crc
);
  logic [31:0] crc_q, crc_n;

  always_comb begin
    crc_n = crc_q;
    if (init)    crc_n = 32'hFFFF_FFFF;
    else if (en) crc_n = crc_step_nib(crc_q, nib);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= 32'hFFFF_FFFF;
    else        crc_q <= crc_n;
  end

  assign crc = crc_q;
endmodule

// File: rtl/pdrx_objbank.sv
module pdrx_objbank #(
  parameter int N  = 7,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          we,
  input  logic [SW-1:0] sel,
  input  logic [31:0]   din,
  output logic [N*32-1:0] dout
);
  for (genvar i = 0; i < N; i++) begin : g_word
    logic [31:0] w_q, w_n;
    always_comb begin
      w_n = w_q;
      if (clr)                          w_n = '0;
      else if (we && sel == SW'(i))     w_n = din;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) w_q <= '0;
      else        w_q <= w_n;
    end
    assign dout[i*32 +: 32] = w_q;
  end
endmodule

// File: rtl/pdrx_framer.sv
module pdrx_framer
  import pdrx_pkg::*;
#(
  parameter int PRE_MIN  = 32,
  parameter int HUNT_MAX = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bit_vld,
  input  logic                   bit_in,
  input  logic                   burst_end,
  output logic                   pkt_ok,
  output logic                   hard_rst,
  output logic                   err_vld,
  output logic [2:0]             err_code,
  output logic [15:0]            rx_hdr,
  output logic [OBJ_MAX*32-1:0]  rx_obj
);
  localparam int HW = $clog2(HUNT_MAX + 1);

  pdrx_st_e        st_q, st_n;
  pdrx_fld_e       fld_q, fld_n;
  logic [19:0]     win_q, win_n;
  logic [HW-1:0]   hunt_q, hunt_n;
  logic [2:0]      b5_q, b5_n;
  logic [2:0]      fc_q, fc_n;
  logic [CNT_W-1:0] wi_q, wi_n, cnt_q, cnt_n;
  logic [15:0]     hdr_q, hdr_n;
  logic [31:0]     word_q, word_n;
  logic [1:0]      ec_q, ec_n;
  logic            ok_q, ok_n, hr_q, hr_n, ev_q, ev_n;
  logic [2:0]      code_q, code_n;

  logic            pre_arm, pre_hit, pre_seen;
  logic [3:0]      nib;
  logic            is_data;
  logic            crc_init, crc_en;
  logic [31:0]     crc_cur;
  logic            obj_clr, obj_we;

  assign win_n   = bit_vld ? {bit_in, win_q[19:1]} : win_q;
  assign pre_arm = (st_q == ST_IDLE) && !burst_end;

  pdrx_pre #(.PRE_MIN(PRE_MIN)) u_pre (
    .clk(clk), .rst_n(rst_n), .arm(pre_arm), .bit_vld(bit_vld),
    .bit_in(bit_in), .hit(pre_hit), .seen(pre_seen)
  );

  pdrx_symdec u_dec (.code(win_n[19:15]), .nib(nib), .is_data(is_data));

  pdrx_crc32 u_crc (
    .clk(clk), .rst_n(rst_n), .init(crc_init), .en(crc_en),
    .nib(nib), .crc(crc_cur)
  );

  pdrx_objbank #(.N(OBJ_MAX), .SW(CNT_W)) u_obj (
    .clk(clk), .rst_n(rst_n), .clr(obj_clr), .we(obj_we),
    .sel(wi_q), .din(word_n), .dout(rx_obj)
  );

  always_comb begin
    st_n     = st_q;
    fld_n    = fld_q;
    hunt_n   = hunt_q;
    b5_n     = b5_q;
    fc_n     = fc_q;
    wi_n     = wi_q;
    cnt_n    = cnt_q;
    hdr_n    = hdr_q;
    word_n   = word_q;
    ec_n     = ec_q;
    code_n   = code_q;
    ok_n     = 1'b0;
    hr_n     = 1'b0;
    ev_n     = 1'b0;
    crc_init = 1'b0;
    crc_en   = 1'b0;
    obj_clr  = 1'b0;
    obj_we   = 1'b0;

    case (st_q)
      ST_IDLE: begin
        if (burst_end) begin
          if (pre_seen) begin
            ev_n   = 1'b1;
            code_n = E_PRE;
          end
        end else if (pre_hit) begin
          st_n   = ST_HUNT;
          hunt_n = '0;
        end
      end

      ST_HUNT: begin
        if (burst_end) begin
          ev_n   = 1'b1;
          code_n = E_SOP;
          st_n   = ST_IDLE;
        end else if (bit_vld) begin
          if (win_n == OS_SOP) begin
            st_n     = ST_BODY;
            fld_n    = FLD_HDR;
            b5_n     = '0;
            fc_n     = '0;
            wi_n     = '0;
            crc_init = 1'b1;
            obj_clr  = 1'b1;
          end else if (win_n == OS_HRST) begin
            hr_n = 1'b1;
            st_n = ST_DRAIN;
          end else if (win_n == OS_SOP1 || win_n == OS_SOP2) begin
            ev_n   = 1'b1;
            code_n = E_SOPX;
            st_n   = ST_DRAIN;
          end else if (hunt_q == HW'(HUNT_MAX - 1)) begin
            ev_n   = 1'b1;
            code_n = E_SOP;
            st_n   = ST_DRAIN;
          end else begin
            hunt_n = hunt_q + 1'b1;
          end
        end
      end

      ST_BODY: begin
        if (burst_end) begin
          ev_n   = 1'b1;
          code_n = E_LEN;
          st_n   = ST_IDLE;
        end else if (bit_vld) begin
          if (b5_q != 3'd4) begin
            b5_n = b5_q + 1'b1;
          end else begin
            b5_n = '0;
            if (!is_data) begin
              ev_n   = 1'b1;
              code_n = E_LEN;
              st_n   = ST_DRAIN;
            end else begin
              fc_n = fc_q + 1'b1;
              case (fld_q)
                FLD_HDR: begin
                  hdr_n  = {nib, hdr_q[15:4]};
                  crc_en = 1'b1;
                  if (fc_q == 3'd3) begin
                    cnt_n = nib[CNT_W-1:0];
                    fc_n  = '0;
                    fld_n = (nib[CNT_W-1:0] == '0) ? FLD_CRC : FLD_DATA;
                  end
                end
                FLD_DATA: begin
                  word_n = {nib, word_q[31:4]};
                  crc_en = 1'b1;
                  if (fc_q == 3'd7) begin
                    obj_we = 1'b1;
                    wi_n   = wi_q + 1'b1;
                    if (wi_q + 1'b1 == cnt_q) fld_n = FLD_CRC;
                  end
                end
                default: begin
                  word_n = {nib, word_q[31:4]};
                  if (fc_q == 3'd7) begin
                    if (word_n != ~crc_cur) begin
                      ev_n   = 1'b1;
                      code_n = E_CRC;
                      st_n   = ST_DRAIN;
                    end else begin
                      st_n = ST_EOP;
                      ec_n = '0;
                    end
                  end
                end
              endcase
            end
          end
        end
      end

      ST_EOP: begin
        if (burst_end) begin
          ev_n   = 1'b1;
          code_n = E_EOP;
          st_n   = ST_IDLE;
        end else if (bit_vld) begin
          if (ec_q == 2'd3) begin
            st_n = ST_DRAIN;
            if (win_n[19:16] == SYM_EOP[3:0]) begin
              ok_n = 1'b1;
            end else begin
              ev_n   = 1'b1;
              code_n = E_EOP;
            end
          end else begin
            ec_n = ec_q + 1'b1;
          end
        end
      end

      default: begin
        if (burst_end) st_n = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      fld_q  <= FLD_HDR;
      win_q  <= '0;
      hunt_q <= '0;
      b5_q   <= '0;
      fc_q   <= '0;
      wi_q   <= '0;
      cnt_q  <= '0;
      hdr_q  <= '0;
      word_q <= '0;
      ec_q   <= '0;
      code_q <= E_NONE;
      ok_q   <= 1'b0;
      hr_q   <= 1'b0;
      ev_q   <= 1'b0;
    end else begin
      st_q   <= st_n;
      fld_q  <= fld_n;
      win_q  <= win_n;
      hunt_q <= hunt_n;
      b5_q   <= b5_n;
      fc_q   <= fc_n;
      wi_q   <= wi_n;
      cnt_q  <= cnt_n;
      hdr_q  <= hdr_n;
      word_q <= word_n;
      ec_q   <= ec_n;
      code_q <= code_n;
      ok_q   <= ok_n;
      hr_q   <= hr_n;
      ev_q   <= ev_n;
    end
  end

  assign pkt_ok   = ok_q;
  assign hard_rst = hr_q;
  assign err_vld  = ev_q;
  assign err_code = code_q;
  assign rx_hdr   = hdr_q;
endmodule

// File: rtl/pdrx_framer_chk.sv
module pdrx_framer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_vld,
  input logic       burst_end,
  input logic       pkt_ok,
  input logic       hard_rst,
  input logic       err_vld,
  input logic [2:0] err_code
);
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pkt_ok, hard_rst, err_vld})); // R12

  AST_PKT_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_ok |-> $past(bit_vld)); // R7

  AST_HRST_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    hard_rst |-> $past(bit_vld)); // R8

  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    err_vld |-> (err_code != 3'd0 && err_code <= 3'd6)); // R10

  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !err_vld |-> $stable(err_code)); // R1

  AST_PRE_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
    (err_vld && err_code == 3'd1) |-> $past(burst_end)); // R2
endmodule

bind pdrx_framer pdrx_framer_chk u_chk (.*);

// File: tb/pdrx_framer_test.sv
`timescale 1ns/1ps
module pdrx_framer_test;
  localparam int OBJW = 7 * 32;

  logic clk, rst_n, bit_vld, bit_in, burst_end;
  logic pkt_ok, hard_rst, err_vld;
  logic [2:0] err_code;
  logic [15:0] rx_hdr;
  logic [OBJW-1:0] rx_obj;

  int tests, fails;
  bit finished;

  typedef struct {
    int          kind;   // 0 packet, 1 error, 2 hard reset
    logic [2:0]  code;
    logic [15:0] hdr;
    logic [OBJW-1:0] data;
    string       tag;
  } exp_t;
  exp_t sb[$];

  pdrx_framer uut (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
    .burst_end(burst_end), .pkt_ok(pkt_ok), .hard_rst(hard_rst),
    .err_vld(err_vld), .err_code(err_code), .rx_hdr(rx_hdr), .rx_obj(rx_obj)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  localparam logic [4:0] K_S1 = 5'b11000, K_S2 = 5'b10001, K_S3 = 5'b00110;
  localparam logic [4:0] K_R1 = 5'b00111, K_R2 = 5'b11001, K_EOP = 5'b01101;

  function automatic logic [4:0] enc(input logic [3:0] n);
    case (n)
      4'h0: enc = 5'b11110; 4'h1: enc = 5'b01001; 4'h2: enc = 5'b10100;
      4'h3: enc = 5'b10101; 4'h4: enc = 5'b01010; 4'h5: enc = 5'b01011;
      4'h6: enc = 5'b01110; 4'h7: enc = 5'b01111; 4'h8: enc = 5'b10010;
      4'h9: enc = 5'b10011; 4'hA: enc = 5'b10110; 4'hB: enc = 5'b10111;
      4'hC: enc = 5'b11010; 4'hD: enc = 5'b11011; 4'hE: enc = 5'b11100;
      default: enc = 5'b11101;
    endcase
  endfunction

  function automatic logic [31:0] ref_crc(input logic [15:0] h,
                                          input logic [OBJW-1:0] d, input int n);
    logic [31:0] c;
    logic fb;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < 16; i++) begin
      fb = c[0] ^ h[i]; c = c >> 1; if (fb) c = c ^ 32'hEDB88320;
    end
    for (int w = 0; w < n; w++)
      for (int i = 0; i < 32; i++) begin
        fb = c[0] ^ d[w*32+i]; c = c >> 1; if (fb) c = c ^ 32'hEDB88320;
      end
    return ~c;
  endfunction

  task automatic put_bit(input logic b);
    bit_in = b; bit_vld = 1'b1;
    @(negedge clk);
    bit_vld = 1'b0;
  endtask

  task automatic put_sym(input logic [4:0] s);
    for (int i = 0; i < 5; i++) put_bit(s[i]);
  endtask

  task automatic put_word(input logic [31:0] w, input int nibs);
    for (int i = 0; i < nibs; i++) put_sym(enc(w[i*4 +: 4]));
  endtask

  task automatic put_pre(input int n);
    for (int i = 0; i < n; i++) put_bit(i[0]);
  endtask

  task automatic end_burst();
    burst_end = 1'b1;
    @(negedge clk);
    burst_end = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic push(input int kind, input logic [2:0] code, input logic [15:0] h,
                      input logic [OBJW-1:0] d, input string tag);
    exp_t e;
    e.kind = kind; e.code = code; e.hdr = h; e.data = d; e.tag = tag;
    sb.push_back(e);
  endtask

  // eop_mode: 0 full code, 1 first four bits only, 2 wrong code
  task automatic send_pkt(input logic [15:0] h, input logic [OBJW-1:0] d,
                          input logic [31:0] crc_x, input int eop_mode, input bit do_end);
    int n;
    n = int'(h[14:12]);
    put_pre(64);
    put_sym(K_S1); put_sym(K_S1); put_sym(K_S1); put_sym(K_S2);
    put_word({16'h0, h}, 4);
    for (int w = 0; w < n; w++) put_word(d[w*32 +: 32], 8);
    put_word(ref_crc(h, d, n) ^ crc_x, 8);
    if (eop_mode == 0)      put_sym(K_EOP);
    else if (eop_mode == 1) for (int i = 0; i < 4; i++) put_bit(K_EOP[i]);
    else                    put_sym(5'b00000);
    if (do_end) end_burst();
  endtask

  function automatic logic [OBJW-1:0] mask_objs(input logic [OBJW-1:0] d, input int n);
    logic [OBJW-1:0] r;
    r = '0;
    for (int w = 0; w < n; w++) r[w*32 +: 32] = d[w*32 +: 32];
    return r;
  endfunction

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && (pkt_ok || err_vld || hard_rst)) begin
        exp_t e;
        int kind;
        tests++;
        kind = pkt_ok ? 0 : (err_vld ? 1 : 2);
        if (sb.size() == 0) begin
          fails++;
          $display("FAIL R12 unexpected outcome: actual kind=%0d code=%0d expected none",
                   kind, err_code);
        end else begin
          e = sb.pop_front();
          if (kind != e.kind) begin
            fails++;
            $display("FAIL %s kind: actual=%0d (code %0d) expected=%0d (code %0d)",
                     e.tag, kind, err_code, e.kind, e.code);
          end else if (kind == 1 && err_code != e.code) begin
            fails++;
            $display("FAIL %s err_code: actual=%0d expected=%0d", e.tag, err_code, e.code);
          end else if (kind == 0 && (rx_hdr != e.hdr || rx_obj != e.data)) begin
            fails++;
            $display("FAIL %s payload: actual hdr=%h obj=%h expected hdr=%h obj=%h",
                     e.tag, rx_hdr, rx_obj, e.hdr, e.data);
          end
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [OBJW-1:0] d7, d2;
    tests = 0; fails = 0; finished = 0;
    rst_n = 1'b0; bit_vld = 1'b0; bit_in = 1'b0; burst_end = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tests++;
    if (pkt_ok || hard_rst || err_vld || err_code != 3'd0) begin
      fails++;
      $display("FAIL R1 reset outputs: actual=%b%b%b/%0d expected=000/0",
               pkt_ok, hard_rst, err_vld, err_code);
    end

    d7 = {32'h5A5A_0FF0, 32'hDEAD_BEEF, 32'h1357_9BDF, 32'h0246_8ACE,
          32'hFFFF_0000, 32'h89AB_CDEF, 32'h0123_4567};
    d2 = {160'h0, 32'hCAFE_F00D, 32'h8000_0001};

    // R3: header only, full end code
    push(0, 3'd0, 16'h0041, '0, "R3");
    send_pkt(16'h0041, '0, 32'h0, 0, 1'b1);

    // R4 R5: seven objects covering every nibble value
    push(0, 3'd0, 16'h7123, d7, "R4/R5");
    send_pkt(16'h7123, d7, 32'h0, 0, 1'b1);

    // R4 R7: two objects, others cleared, end code cut to four bits
    push(0, 3'd0, 16'h2C61, mask_objs(d2, 2), "R4/R7 short eop");
    send_pkt(16'h2C61, d2, 32'h0, 1, 1'b1);

    // R6: corrupted CRC
    push(1, 3'd5, 16'h0, '0, "R6");
    send_pkt(16'h1A0F, d2, 32'h0000_0100, 0, 1'b1);

    // R7: wrong end code
    push(1, 3'd6, 16'h0, '0, "R7 bad eop");
    send_pkt(16'h0041, '0, 32'h0, 2, 1'b1);

    // R8: hard reset
    push(2, 3'd0, 16'h0, '0, "R8");
    put_pre(64); put_sym(K_R1); put_sym(K_R1); put_sym(K_R1); put_sym(K_R2);
    end_burst();

    // R9: both unsupported start sets
    push(1, 3'd3, 16'h0, '0, "R9 prime");
    put_pre(64); put_sym(K_S1); put_sym(K_S1); put_sym(K_S3); put_sym(K_S3);
    end_burst();
    push(1, 3'd3, 16'h0, '0, "R9 double prime");
    put_pre(64); put_sym(K_S1); put_sym(K_S3); put_sym(K_S1); put_sym(K_S3);
    end_burst();

    // R10: burst cut inside an object
    push(1, 3'd4, 16'h0, '0, "R10 cut");
    put_pre(64); put_sym(K_S1); put_sym(K_S1); put_sym(K_S1); put_sym(K_S2);
    put_word(32'h1001, 4); put_word(32'h1234_5678, 3);
    end_burst();

    // R10: illegal code in header, then a K-code in header
    push(1, 3'd4, 16'h0, '0, "R10 bad symbol");
    put_pre(64); put_sym(K_S1); put_sym(K_S1); put_sym(K_S1); put_sym(K_S2);
    put_word(32'h21, 2); put_sym(5'b00000); put_word(32'h77, 2);
    end_burst();
    push(1, 3'd4, 16'h0, '0, "R10 kcode");
    put_pre(64); put_sym(K_S1); put_sym(K_S1); put_sym(K_S1); put_sym(K_S2);
    put_word(32'h3, 1); put_sym(K_EOP);
    end_burst();

    // R2: short preamble, then non-alternating noise
    push(1, 3'd1, 16'h0, '0, "R2 short");
    put_pre(10); end_burst();
    push(1, 3'd1, 16'h0, '0, "R2 noise");
    for (int i = 0; i < 40; i++) put_bit(1'b0);
    end_burst();

    // R11: no start set before burst end, then search limit
    push(1, 3'd2, 16'h0, '0, "R11 end");
    put_pre(64); end_burst();
    push(1, 3'd2, 16'h0, '0, "R11 limit");
    put_pre(300); end_burst();

    // R12: second frame inside ignore window is silent, next burst decodes
    push(0, 3'd0, 16'h0041, '0, "R12 first");
    send_pkt(16'h0041, '0, 32'h0, 0, 1'b0);
    send_pkt(16'h2C61, d2, 32'h0, 0, 1'b1);
    push(0, 3'd0, 16'h2C61, mask_objs(d2, 2), "R12 recover");
    send_pkt(16'h2C61, d2, 32'h0, 0, 1'b1);

    repeat (20) @(negedge clk);
    tests++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R12 missing outcomes: actual=%0d pending expected=0 (next %s)",
               sb.size(), sb[0].tag);
    end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule